// File: doc/BRIEF.md
# Bus readiness sequencer

This block decides when the serial-bus front end of a device may start to see edges on its data and clock lines. It watches a supply-good flag, an active-low reset pin, a power-down pin and a security-delay request. From these it produces three registered outputs: a bus-enable that gates the bus edge detectors, a sleep flag, and an active-low reset for the core logic.

After the later of supply-good rising and the reset pin releasing, the block counts a boot interval of millisecond ticks before it raises the bus enable. A pending security delay lengthens that interval by a penalty count that another block supplies. Raising the power-down pin puts the block to sleep and blocks the bus at once. Lowering it again starts a separate, shorter wake guard.

The millisecond tick, the security request and the penalty count come from logic clocked by `clk`. The reset pin, supply-good and power-down are asynchronous and are synchronized inside the block.

Top module: `rdy_seq`

## Requirements
- R1: While `rst_pin_n` is low, `bus_en`, `sleep` and `core_rst_n` are all 0. This takes effect at once, without a clock edge, whatever the level of `pdown`.
- R2: Once both the synchronized reset release and the synchronized supply-good are seen, the block loads a 60-tick interval. `bus_en` rises on the clock edge after the 60th `ms_tick` that follows the load. Ticks that arrive before the load are not counted.
- R3: If `sec_pending` is 1 when the boot interval is loaded, the interval is 60 plus `pen_ms` ticks. If `sec_pending` is 0, `pen_ms` has no effect.
- R4: When `supply_ok` falls, `bus_en` and `core_rst_n` go to 0. When it returns, a full boot interval is counted again.
- R5: While `pdown` is high (after synchronization), `sleep` is 1, `bus_en` is 0, and `ms_tick` pulses do not advance anything.
- R6: After `pdown` falls, `bus_en` stays 0 for 50 ticks and rises on the clock edge after the 50th tick.
- R7: A rise of `pdown` during a pending boot or wake interval cancels that interval. The next fall of `pdown` starts a fresh 50-tick guard.
- R8: `core_rst_n` is 0 only while reset or supply-good is still pending. It is 1 while counting, while running and while asleep.
- R9: A level change on `pdown` reaches `sleep` on the third rising clock edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_pin_n | input | 1 | Active-low reset pin, asynchronous |
| supply_ok | input | 1 | Supply-good flag from the analog monitor, asynchronous |
| pdown | input | 1 | Power-down pin, high requests sleep, asynchronous |
| sec_pending | input | 1 | A security penalty is owed at the next boot load |
| pen_ms | input | PEN_W | Penalty length in ticks |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| bus_en | output | 1 | Serial bus edges may be accepted |
| sleep | output | 1 | Device is asleep |
| core_rst_n | output | 1 | Active-low reset for the core logic |

## Verification
The hardest state to reach is a power-down pulse that lands while an interval is partly counted down. From that state the block must drop the remainder and restart the shorter wake guard, not the boot count. The stimulus reaches it by counting part of a wake guard with explicit tick pulses, raising and then lowering `pdown`, and then showing that exactly 50 more ticks are needed. Ticks are produced only by the bench, one at a time, and never while a load is in flight. This lets every interval length be checked to the exact tick, at its last-but-one tick and at its last tick.

// File: rtl/rdy_pkg.sv
package rdy_pkg;

    typedef enum logic [1:0] {
        RDY_HOLD  = 2'd0,   // reset or supply not yet released
        RDY_WAIT  = 2'd1,   // counting a boot or wake interval
        RDY_LIVE  = 2'd2,   // bus accepted
        RDY_SLEEP = 2'd3    // power-down pin high
    } rdy_state_e;

    typedef struct packed {
        rdy_state_e state;
        logic       bus_en;
        logic       sleep;
        logic       core_rst_n;
    } rdy_regs_t;

endpackage

// File: rtl/rdy_sync.sv
module rdy_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stg_q[0] <= RST_VAL;
        else         stg_q[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) stg_q[g] <= RST_VAL;
            else         stg_q[g] <= stg_q[g-1];
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/rdy_interval.sv
module rdy_interval #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)                    cnt_d = '0;
        else if (load)                cnt_d = load_val;
        else if (tick && cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q;
    assign zero = (cnt_q == '0);

endmodule

// File: rtl/rdy_seq.sv
module rdy_seq
    import rdy_pkg::*;
#(
    parameter int BOOT_MS     = 60,
    parameter int WAKE_MS     = 50,
    parameter int PEN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_pin_n,
    input  logic             supply_ok,
    input  logic             pdown,
    input  logic             sec_pending,
    input  logic [PEN_W-1:0] pen_ms,
    input  logic             ms_tick,
    output logic             bus_en,
    output logic             sleep,
    output logic             core_rst_n
);

    localparam int               CNT_W   = $clog2(BOOT_MS + (1 << PEN_W));
    localparam logic [CNT_W-1:0] BOOT_LD = CNT_W'(BOOT_MS);
    localparam logic [CNT_W-1:0] WAKE_LD = CNT_W'(WAKE_MS);

    logic       rst_s;
    logic [1:0] pins_s;
    logic       sup_s;
    logic       pdn_s;

    // reset release: async assert, synchronized deassert
    rdy_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
        .clk    (clk),
        .arst_n (rst_pin_n),
        .d      (1'b1),
        .q      (rst_s)
    );

    rdy_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_pin_sync (
        .clk    (clk),
        .arst_n (rst_pin_n),
        .d      ({supply_ok, pdown}),
        .q      (pins_s)
    );

    assign sup_s = pins_s[1];
    assign pdn_s = pins_s[0];

    logic             cnt_load;
    logic             cnt_clear;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_zero;

    rdy_interval #(.CNT_W(CNT_W)) u_interval (
        .clk      (clk),
        .arst_n   (rst_pin_n),
        .clear    (cnt_clear),
        .load     (cnt_load),
        .load_val (cnt_val),
        .tick     (ms_tick),
        .cnt      (cnt_q),
        .zero     (cnt_zero)
    );

    rdy_regs_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        cnt_load  = 1'b0;
        cnt_clear = 1'b0;
        cnt_val   = BOOT_LD;

        if (!rst_s || !sup_s) begin
            seq_d.state = RDY_HOLD;
            cnt_clear   = 1'b1;
        end else begin
            unique case (seq_q.state)
                RDY_HOLD: begin
                    if (pdn_s) begin
                        seq_d.state = RDY_SLEEP;
                    end else begin
                        cnt_load    = 1'b1;
                        cnt_val     = BOOT_LD + (sec_pending ? CNT_W'(pen_ms) : '0);
                        seq_d.state = RDY_WAIT;
                    end
                end
                RDY_WAIT: begin
                    if (pdn_s) begin
                        seq_d.state = RDY_SLEEP;
                        cnt_clear   = 1'b1;
                    end else if (cnt_zero) begin
                        seq_d.state = RDY_LIVE;
                    end
                end
                RDY_LIVE: begin
                    if (pdn_s) seq_d.state = RDY_SLEEP;
                end
                RDY_SLEEP: begin
                    if (!pdn_s) begin
                        cnt_load    = 1'b1;
                        cnt_val     = WAKE_LD;
                        seq_d.state = RDY_WAIT;
                    end
                end
                default: seq_d.state = RDY_HOLD;
            endcase
        end

        seq_d.bus_en     = (seq_d.state == RDY_LIVE);
        seq_d.sleep      = pdn_s;
        seq_d.core_rst_n = (seq_d.state != RDY_HOLD);
    end

    always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n) begin
            seq_q.state      <= RDY_HOLD;
            seq_q.bus_en     <= 1'b0;
            seq_q.sleep      <= 1'b0;
            seq_q.core_rst_n <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign bus_en     = seq_q.bus_en;
    assign sleep      = seq_q.sleep;
    assign core_rst_n = seq_q.core_rst_n;

endmodule

// File: rtl/rdy_seq_chk.sv
module rdy_seq_chk #(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_en,
    input logic             sleep,
    input logic             core_rst_n,
    input logic             ms_tick,
    input logic             cnt_load,
    input logic             cnt_clear,
    input logic [CNT_W-1:0] cnt_q
);

    // R5: the sleep flag and the bus enable are never both high
    a_r5_sleep_blocks_bus: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !bus_en);

    // R2: the bus opens only after the interval counter has run out
    a_r2_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_en) |-> ($past(cnt_q) == '0));

    // R2: each tick takes exactly one off a running interval
    a_r2_tick_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_tick && !cnt_load && !cnt_clear && cnt_q != '0)
            |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R4: the core is never running held in reset while the bus is open
    a_r4_hold_blocks_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !core_rst_n |-> !bus_en);

    // R7: entering sleep leaves no interval running
    a_r7_sleep_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sleep) && core_rst_n) |=> (cnt_q == '0 || !sleep));

endmodule

bind rdy_seq rdy_seq_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_pin_n),
    .bus_en     (bus_en),
    .sleep      (sleep),
    .core_rst_n (core_rst_n),
    .ms_tick    (ms_tick),
    .cnt_load   (cnt_load),
    .cnt_clear  (cnt_clear),
    .cnt_q      (cnt_q)
);

// File: tb/rdy_seq_tb_top.sv
module rdy_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_pin_n;
    logic       supply_ok;
    logic       pdown;
    logic       sec_pending;
    logic [7:0] pen_ms;
    logic       ms_tick;
    logic       bus_en;
    logic       sleep;
    logic       core_rst_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rdy_seq dut_i (
        .clk         (clk),
        .rst_pin_n   (rst_pin_n),
        .supply_ok   (supply_ok),
        .pdown       (pdown),
        .sec_pending (sec_pending),
        .pen_ms      (pen_ms),
        .ms_tick     (ms_tick),
        .bus_en      (bus_en),
        .sleep       (sleep),
        .core_rst_n  (core_rst_n)
    );

    typedef struct packed {
        logic       rst;
        logic       sup;
        logic       pdn;
        logic       sec;
        logic [7:0] pen;
        logic [7:0] nt;
        logic       eb;
        logic       es;
        logic       ec;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'd0,  8'd59, 1'b0, 1'b0, 1'b1}, // R2 one short
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'd0,  8'd1,  1'b1, 1'b0, 1'b1}, // R2 sixtieth tick
        '{1'b0, 1'b1, 1'b1, 1'b0, 8'd0,  8'd0,  1'b0, 1'b1, 1'b1}, // R5 sleep
        '{1'b0, 1'b1, 1'b1, 1'b0, 8'd0,  8'd5,  1'b0, 1'b1, 1'b1}, // R5 ticks ignored
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'd0,  8'd49, 1'b0, 1'b0, 1'b1}, // R6 guard pending
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'd0,  8'd1,  1'b1, 1'b0, 1'b1}, // R6 guard done
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'd20, 8'd79, 1'b0, 1'b0, 1'b1}, // R3 penalty short
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'd20, 8'd1,  1'b1, 1'b0, 1'b1}, // R3 penalty done
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'd20, 8'd59, 1'b0, 1'b0, 1'b1}, // R3 count ignored
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'd20, 8'd1,  1'b1, 1'b0, 1'b1}, // R3 plain 60
        '{1'b0, 1'b1, 1'b1, 1'b0, 8'd0,  8'd0,  1'b0, 1'b1, 1'b1}, // R7 sleep
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'd0,  8'd30, 1'b0, 1'b0, 1'b1}, // R7 partial guard
        '{1'b0, 1'b1, 1'b1, 1'b0, 8'd0,  8'd0,  1'b0, 1'b1, 1'b1}, // R7 cancel
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'd0,  8'd49, 1'b0, 1'b0, 1'b1}, // R7 fresh guard
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'd0,  8'd1,  1'b1, 1'b0, 1'b1}, // R7 fresh done
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd0,  1'b0, 1'b0, 1'b0}, // R4 supply lost
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'd0,  8'd59, 1'b0, 1'b0, 1'b1}, // R4 R8 recount
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'd0,  8'd1,  1'b1, 1'b0, 1'b1}  // R4 recount done
    };

    task automatic check(input string req, input string what,
                         input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
            @(negedge clk);
        end
        idle(2);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_pin_n   = 1'b0;
        supply_ok   = 1'b0;
        pdown       = 1'b0;
        sec_pending = 1'b0;
        pen_ms      = 8'd0;
        ms_tick     = 1'b0;
        idle(3);
        // R1 reset state
        check("R1", "bus_en at reset", bus_en, 1'b0);
        check("R1", "sleep at reset", sleep, 1'b0);
        check("R1", "core_rst_n at reset", core_rst_n, 1'b0);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            supply_ok   = VECS[v].sup;
            pdown       = VECS[v].pdn;
            sec_pending = VECS[v].sec;
            pen_ms      = VECS[v].pen;
            if (VECS[v].rst) begin
                rst_pin_n = 1'b0;
                idle(3);
                rst_pin_n = 1'b1;
            end
            idle(6);
            if (VECS[v].nt != 8'd0) ticks(int'(VECS[v].nt));
            check($sformatf("vector %0d", v), "bus_en", bus_en, VECS[v].eb);
            check($sformatf("vector %0d", v), "sleep", sleep, VECS[v].es);
            check($sformatf("vector %0d", v), "core_rst_n", core_rst_n, VECS[v].ec);
        end

        // R9: pdown reaches sleep on the third edge
        @(negedge clk) pdown = 1'b1;
        idle(2);
        check("R9", "sleep after two edges", sleep, 1'b0);
        idle(1);
        check("R9", "sleep after three edges", sleep, 1'b1);
        check("R5", "bus_en with sleep", bus_en, 1'b0);

        // R1: reset while pdown is high, takes effect without a clock
        @(negedge clk) rst_pin_n = 1'b0;
        #1;
        check("R1", "sleep async", sleep, 1'b0);
        check("R1", "core_rst_n async", core_rst_n, 1'b0);
        check("R1", "bus_en async", bus_en, 1'b0);
        idle(2);
        rst_pin_n = 1'b1;
        idle(6);
        check("R8", "core_rst_n in sleep", core_rst_n, 1'b1);
        check("R5", "sleep after release", sleep, 1'b1);
        ticks(70);
        check("R5", "bus_en after ticks in sleep", bus_en, 1'b0);
        pdown = 1'b0;
        idle(6);
        ticks(49);
        check("R6", "bus_en after 49", bus_en, 1'b0);
        ticks(1);
        check("R6", "bus_en after 50", bus_en, 1'b1);

        // R2: supply first, reset released later
        @(negedge clk);
        supply_ok = 1'b0;
        rst_pin_n = 1'b0;
        idle(4);
        supply_ok = 1'b1;
        idle(20);
        check("R8", "core_rst_n while pin held", core_rst_n, 1'b0);
        rst_pin_n = 1'b1;
        idle(6);
        check("R8", "core_rst_n after release", core_rst_n, 1'b1);
        ticks(59);
        check("R2", "bus_en reset-late 59", bus_en, 1'b0);
        ticks(1);
        check("R2", "bus_en reset-late 60", bus_en, 1'b1);

        // R2: reset first, supply later; early ticks must not count
        @(negedge clk);
        supply_ok = 1'b0;
        rst_pin_n = 1'b0;
        idle(3);
        rst_pin_n = 1'b1;
        idle(10);
        ticks(10);
        check("R8", "core_rst_n without supply", core_rst_n, 1'b0);
        check("R4", "bus_en without supply", bus_en, 1'b0);
        supply_ok = 1'b1;
        idle(6);
        ticks(59);
        check("R2", "bus_en supply-late 59", bus_en, 1'b0);
        ticks(1);
        check("R2", "bus_en supply-late 60", bus_en, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule